// File: doc/BRIEF.md
# Character Dot-Sequence Address Generator

This block produces the addresses and beam coordinates that draw text on a vector display as a series of dots. A character-position counter, split into a column field and a line field, addresses an external character RAM. The 7-bit character code that the RAM returns is joined with a 5-bit dot index to address an external glyph ROM. Each ROM word is one dot of that glyph's ordered dot list: a horizontal offset, a vertical offset and a terminator bit that marks the final dot. The block adds the offsets to the origin of the current character cell and registers the resulting deflection DAC codes. Alongside them it registers an active-low end-of-character signal and a beam-enable for the visible columns.

An external sequencer sets the pace with two single-cycle strobes. One strobe advances to the next dot of the current glyph. The other advances to the next character position and restarts the dot index. The strobes are plain control pins, and the block applies no back-pressure. The RAM and ROM are read combinationally: the data they return must settle within the same cycle as the address that drives them. The DAC codes, end-of-character and beam-enable are registered and trail the address outputs by one clock. Two combinational flags mark column 11 and column 63. The column-63 flag tells the sequencer that the next character starts a new line.

Top module: `char_dot_addrgen`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises with no strobe applied, the column, line and dot index are zero, `dac_x` and `dac_y` are 0, `eoc_n` is 1 and `beam_on` is 0.
- R2: `ram_addr` is {line[3:0], column[5:0]}. A `char_step` strobe increments the column. Column 63 wraps to 0 and increments the line, and line 15 wraps to 0.
- R3: `rom_addr` is {ram_code[6:0], dot[4:0]}, with the character code in bits 11:5 and the dot index in bits 4:0.
- R4: A `dot_step` strobe increments the dot index modulo 32. A `char_step` strobe clears the dot index to 0 and takes priority when both strobes are high in the same cycle.
- R5: One clock after an address is presented, `dac_x` equals column*16 plus `rom_word[11:6]`, and `dac_y` equals line*64 plus `rom_word[5:0]`.
- R6: One clock after an address is presented, `eoc_n` is 0 exactly when the terminator bit `rom_word[12]` of that dot's word is 1.
- R7: `flag_col11` is 1 exactly when the column is 11. `flag_eol` is 1 exactly when the column is 63.
- R8: One clock after an address is presented, `beam_on` is 1 exactly when that column lies in the visible window 12 to 51, which is the center 40 of the 64 positions.
- R9: In a cycle with neither strobe high, the column, line and dot index keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_step | input | 1 | Advance to the next dot of the current glyph |
| char_step | input | 1 | Advance to the next character position and clear the dot index |
| ram_addr | output | 10 | Character RAM address {line, column} |
| ram_code | input | 7 | Character code returned by the RAM |
| rom_addr | output | 12 | Glyph ROM address {code, dot} |
| rom_word | input | 13 | Glyph ROM word {terminator, x offset, y offset} |
| dac_x | output | 12 | Horizontal deflection code |
| dac_y | output | 12 | Vertical deflection code |
| eoc_n | output | 1 | End of character, active low, on the final dot |
| beam_on | output | 1 | Beam enable for the visible columns |
| flag_col11 | output | 1 | Column 11 reached |
| flag_eol | output | 1 | Column 63 reached; the next character starts a new line |

## Verification
The main function is driven by a fixed mix of dot strobes, character strobes, simultaneous strobes and idle cycles. The RAM and ROM models return data that depends on both the code and the dot index, so a swapped field, a missing cell origin or a late register stage yields a wrong DAC code. Walking the dot index of one glyph past its terminator tells a correct end-of-character apart from one that is stuck or shifted by a dot. Long runs of character strobes reach column 11, the window edges 11/12 and 51/52, column 63 and the line wrap from 15 to 0, which separates correct boundary logic from off-by-one errors. The 31-to-0 dot wrap is also tried.

// File: rtl/cdg_pkg.sv
package cdg_pkg;

  // Action applied to the per-character dot index on a clock edge
  typedef enum logic [1:0] {
    DOT_HOLD = 2'd0,
    DOT_INC  = 2'd1,
    DOT_CLR  = 2'd2
  } dot_act_e;

  // Default geometry of the character grid
  localparam int unsigned CDG_COL_W  = 6;
  localparam int unsigned CDG_LINE_W = 4;
  localparam int unsigned CDG_CODE_W = 7;
  localparam int unsigned CDG_DOT_W  = 5;
  localparam int unsigned CDG_OFF_W  = 6;
  localparam int unsigned CDG_DAC_W  = 12;

  // Strobe decode: a character advance restarts the glyph, so it wins
  function automatic dot_act_e dot_action(input logic dot_stb, input logic chr_stb);
    if (chr_stb)      return DOT_CLR;
    else if (dot_stb) return DOT_INC;
    else              return DOT_HOLD;
  endfunction

endpackage

// File: rtl/cdg_pos_counter.sv
module cdg_pos_counter #(
  parameter int unsigned COL_W   = 6,
  parameter int unsigned LINE_W  = 4,
  parameter int unsigned MARK_COL = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [COL_W-1:0]  col,
  output logic [LINE_W-1:0] line,
  output logic              at_mark,
  output logic              at_last
);

  localparam logic [COL_W-1:0] LAST_COL = {COL_W{1'b1}};
  localparam logic [COL_W-1:0] MARK_V   = COL_W'(MARK_COL);

  logic [COL_W-1:0]  col_d;
  logic [LINE_W-1:0] line_d;

  always_comb begin
    col_d  = col;
    line_d = line;
    if (adv) begin
      col_d = col + COL_W'(1);
      if (col == LAST_COL) begin
        line_d = line + LINE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col  <= '0;
      line <= '0;
    end else begin
      col  <= col_d;
      line <= line_d;
    end
  end

  assign at_mark = (col == MARK_V);
  assign at_last = (col == LAST_COL);

endmodule

// File: rtl/cdg_dot_counter.sv
module cdg_dot_counter
  import cdg_pkg::*;
#(
  parameter int unsigned DOT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dot_stb,
  input  logic             chr_stb,
  output logic [DOT_W-1:0] dot
);

  dot_act_e act;

  assign act = dot_action(dot_stb, chr_stb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot <= '0;
    end else begin
      unique case (act)
        DOT_CLR:  dot <= '0;
        DOT_INC:  dot <= dot + DOT_W'(1);
        default:  dot <= dot;
      endcase
    end
  end

endmodule

// File: rtl/cdg_dac_stage.sv
module cdg_dac_stage #(
  parameter int unsigned COL_W     = 6,
  parameter int unsigned LINE_W    = 4,
  parameter int unsigned OFF_W     = 6,
  parameter int unsigned DAC_W     = 12,
  parameter int unsigned X_PITCH   = 16,
  parameter int unsigned Y_PITCH   = 64,
  parameter int unsigned VIS_FIRST = 12,
  parameter int unsigned VIS_COUNT = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COL_W-1:0]  col,
  input  logic [LINE_W-1:0] line,
  input  logic [OFF_W-1:0]  x_off,
  input  logic [OFF_W-1:0]  y_off,
  input  logic              last_dot,
  output logic [DAC_W-1:0]  dac_x,
  output logic [DAC_W-1:0]  dac_y,
  output logic              eoc_n,
  output logic              beam_on
);

  localparam int unsigned VIS_LAST = VIS_FIRST + VIS_COUNT - 1;

  logic [DAC_W-1:0] org_x;
  logic [DAC_W-1:0] org_y;
  logic [DAC_W-1:0] pos_x;
  logic [DAC_W-1:0] pos_y;
  logic             vis;

  always_comb begin
    org_x = DAC_W'(col)  * DAC_W'(X_PITCH);
    org_y = DAC_W'(line) * DAC_W'(Y_PITCH);
    pos_x = org_x + DAC_W'(x_off);
    pos_y = org_y + DAC_W'(y_off);
    vis   = (int'(col) >= int'(VIS_FIRST)) && (int'(col) <= int'(VIS_LAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_x   <= '0;
      dac_y   <= '0;
      eoc_n   <= 1'b1;
      beam_on <= 1'b0;
    end else begin
      dac_x   <= pos_x;
      dac_y   <= pos_y;
      eoc_n   <= ~last_dot;
      beam_on <= vis;
    end
  end

endmodule

// File: rtl/char_dot_addrgen.sv
module char_dot_addrgen
  import cdg_pkg::*;
#(
  parameter int unsigned COL_W     = CDG_COL_W,
  parameter int unsigned LINE_W    = CDG_LINE_W,
  parameter int unsigned CODE_W    = CDG_CODE_W,
  parameter int unsigned DOT_W     = CDG_DOT_W,
  parameter int unsigned OFF_W     = CDG_OFF_W,
  parameter int unsigned DAC_W     = CDG_DAC_W,
  parameter int unsigned X_PITCH   = 16,
  parameter int unsigned Y_PITCH   = 64,
  parameter int unsigned MARK_COL  = 11,
  parameter int unsigned VIS_FIRST = 12,
  parameter int unsigned VIS_COUNT = 40,
  localparam int unsigned RAM_AW   = LINE_W + COL_W,
  localparam int unsigned ROM_AW   = CODE_W + DOT_W,
  localparam int unsigned ROM_DW   = 1 + 2 * OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dot_step,
  input  logic              char_step,
  output logic [RAM_AW-1:0] ram_addr,
  input  logic [CODE_W-1:0] ram_code,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [ROM_DW-1:0] rom_word,
  output logic [DAC_W-1:0]  dac_x,
  output logic [DAC_W-1:0]  dac_y,
  output logic              eoc_n,
  output logic              beam_on,
  output logic              flag_col11,
  output logic              flag_eol
);

  logic [COL_W-1:0]  col;
  logic [LINE_W-1:0] line;
  logic [DOT_W-1:0]  dot;
  logic [OFF_W-1:0]  x_off;
  logic [OFF_W-1:0]  y_off;
  logic              term;

  cdg_pos_counter #(
    .COL_W   (COL_W),
    .LINE_W  (LINE_W),
    .MARK_COL(MARK_COL)
  ) u_pos (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (char_step),
    .col    (col),
    .line   (line),
    .at_mark(flag_col11),
    .at_last(flag_eol)
  );

  cdg_dot_counter #(
    .DOT_W(DOT_W)
  ) u_dot (
    .clk    (clk),
    .rst_n  (rst_n),
    .dot_stb(dot_step),
    .chr_stb(char_step),
    .dot    (dot)
  );

  // ROM word layout: terminator on top, then X offset, then Y offset
  assign term  = rom_word[ROM_DW-1];
  assign x_off = rom_word[2*OFF_W-1:OFF_W];
  assign y_off = rom_word[OFF_W-1:0];

  assign ram_addr = {line, col};
  assign rom_addr = {ram_code, dot};

  cdg_dac_stage #(
    .COL_W    (COL_W),
    .LINE_W   (LINE_W),
    .OFF_W    (OFF_W),
    .DAC_W    (DAC_W),
    .X_PITCH  (X_PITCH),
    .Y_PITCH  (Y_PITCH),
    .VIS_FIRST(VIS_FIRST),
    .VIS_COUNT(VIS_COUNT)
  ) u_dac (
    .clk     (clk),
    .rst_n   (rst_n),
    .col     (col),
    .line    (line),
    .x_off   (x_off),
    .y_off   (y_off),
    .last_dot(term),
    .dac_x   (dac_x),
    .dac_y   (dac_y),
    .eoc_n   (eoc_n),
    .beam_on (beam_on)
  );

endmodule

// File: rtl/char_dot_addrgen_chk.sv
module char_dot_addrgen_chk #(
  parameter int unsigned COL_W     = 6,
  parameter int unsigned LINE_W    = 4,
  parameter int unsigned DOT_W     = 5,
  parameter int unsigned RAM_AW    = 10,
  parameter int unsigned ROM_AW    = 12,
  parameter int unsigned ROM_DW    = 13,
  parameter int unsigned VIS_FIRST = 12,
  parameter int unsigned VIS_COUNT = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dot_step,
  input logic              char_step,
  input logic [RAM_AW-1:0] ram_addr,
  input logic [ROM_AW-1:0] rom_addr,
  input logic [ROM_DW-1:0] rom_word,
  input logic              eoc_n,
  input logic              beam_on,
  input logic              flag_col11,
  input logic              flag_eol
);

  localparam int unsigned VIS_LAST = VIS_FIRST + VIS_COUNT - 1;

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  logic [COL_W-1:0]  c_col;
  logic [LINE_W-1:0] c_line;
  logic [DOT_W-1:0]  c_dot;
  logic              c_vis;
  assign c_col  = ram_addr[COL_W-1:0];
  assign c_line = ram_addr[RAM_AW-1:COL_W];
  assign c_dot  = rom_addr[DOT_W-1:0];
  assign c_vis  = (int'(c_col) >= int'(VIS_FIRST)) && (int'(c_col) <= int'(VIS_LAST));

  // R4: a character advance restarts the dot list
  p_dot_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    char_step |=> (c_dot == '0));

  // R2: column wrap carries into the line
  p_col_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (char_step && (c_col == {COL_W{1'b1}})) |=>
      ((c_col == '0) && (c_line == LINE_W'($past(c_line) + LINE_W'(1)))));

  // R9: idle cycle leaves the position and dot index untouched
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dot_step && !char_step) |=> ($stable(ram_addr) && $stable(c_dot)));

  // R6: end-of-character follows the terminator of the previous word
  p_eoc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (eoc_n == !$past(rom_word[ROM_DW-1])));

  // R8: beam enable follows the visibility of the previous column
  p_beam_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (beam_on == $past(c_vis)));

  // R7: the two column marks are never raised together
  p_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_col11, flag_eol}));

endmodule

bind char_dot_addrgen char_dot_addrgen_chk #(
  .COL_W    (COL_W),
  .LINE_W   (LINE_W),
  .DOT_W    (DOT_W),
  .RAM_AW   (RAM_AW),
  .ROM_AW   (ROM_AW),
  .ROM_DW   (ROM_DW),
  .VIS_FIRST(VIS_FIRST),
  .VIS_COUNT(VIS_COUNT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dot_step  (dot_step),
  .char_step (char_step),
  .ram_addr  (ram_addr),
  .rom_addr  (rom_addr),
  .rom_word  (rom_word),
  .eoc_n     (eoc_n),
  .beam_on   (beam_on),
  .flag_col11(flag_col11),
  .flag_eol  (flag_eol)
);

// File: tb/sim_char_dot_addrgen.sv
`timescale 1ns/1ps
module sim_char_dot_addrgen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dot_step = 1'b0;
  logic        char_step = 1'b0;
  logic [9:0]  ram_addr;
  logic [6:0]  ram_code;
  logic [11:0] rom_addr;
  logic [12:0] rom_word;
  logic [11:0] dac_x;
  logic [11:0] dac_y;
  logic        eoc_n;
  logic        beam_on;
  logic        flag_col11;
  logic        flag_eol;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_col = 0;
  int m_line = 0;
  int m_dot = 0;

  always #4 clk = ~clk;

  char_dot_addrgen u0 (
    .clk(clk), .rst_n(rst_n), .dot_step(dot_step), .char_step(char_step),
    .ram_addr(ram_addr), .ram_code(ram_code), .rom_addr(rom_addr), .rom_word(rom_word),
    .dac_x(dac_x), .dac_y(dac_y), .eoc_n(eoc_n), .beam_on(beam_on),
    .flag_col11(flag_col11), .flag_eol(flag_eol)
  );

  // Memory models
  function automatic int ram_fn(input int a);
    return (a * 5 + 3) & 127;
  endfunction

  function automatic int rom_fn(input int code, input int dot);
    int term = (dot == ((code & 7) + 3)) ? 1 : 0;
    int xo   = (code ^ (dot * 3)) & 63;
    int yo   = (code + dot * 7) & 63;
    return (term << 12) | (xo << 6) | yo;
  endfunction

  always_comb ram_code = 7'(ram_fn(int'(ram_addr)));
  always_comb rom_word = 13'(rom_fn(int'(rom_addr[11:5]), int'(rom_addr[4:0])));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input bit ds, input bit cs);
    if (cs) begin
      m_dot = 0;
      m_col++;
      if (m_col == 64) begin
        m_col = 0;
        m_line = (m_line + 1) % 16;
      end
    end else if (ds) begin
      m_dot = (m_dot + 1) % 32;
    end
  endtask

  // Strobe for one cycle, then one idle cycle; sample at the following falling edge
  task automatic step(input bit ds, input bit cs);
    @(negedge clk);
    dot_step = ds;
    char_step = cs;
    @(negedge clk);
    dot_step = 1'b0;
    char_step = 1'b0;
    model(ds, cs);
    @(negedge clk);
  endtask

  task automatic check_all();
    int code = ram_fn(m_line * 64 + m_col);
    int w = rom_fn(code, m_dot);
    chk("R2 ram_addr", int'(ram_addr), m_line * 64 + m_col);
    chk("R3 rom_addr", int'(rom_addr), code * 32 + m_dot);
    chk("R5 dac_x", int'(dac_x), m_col * 16 + ((w >> 6) & 63));
    chk("R5 dac_y", int'(dac_y), m_line * 64 + (w & 63));
    chk("R6 eoc_n", int'(eoc_n), ((w >> 12) & 1) ? 0 : 1);
    chk("R7 flag_col11", int'(flag_col11), (m_col == 11) ? 1 : 0);
    chk("R7 flag_eol", int'(flag_eol), (m_col == 63) ? 1 : 0);
    chk("R8 beam_on", int'(beam_on), (m_col >= 12 && m_col <= 51) ? 1 : 0);
  endtask

  // {dot_step, char_step} stimulus vectors
  localparam logic [1:0] VEC [20] = '{
    2'b10, 2'b10, 2'b10, 2'b00, 2'b10, 2'b10, 2'b01, 2'b10,
    2'b11, 2'b10, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b10,
    2'b10, 2'b11, 2'b00, 2'b10
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ram_addr in reset", int'(ram_addr), 0);
    chk("R1 eoc_n in reset", int'(eoc_n), 1);
    chk("R1 dac_x in reset", int'(dac_x), 0);
    chk("R1 beam_on in reset", int'(beam_on), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 dot after reset", int'(rom_addr[4:0]), 0);
    check_all();

    // Vector table walk
    for (int i = 0; i < 20; i++) begin
      step(VEC[i][1], VEC[i][0]);
      check_all();
    end

    // R9: idle cycles hold state
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check_all();

    // R4: dot wrap 31 -> 0
    step(1'b0, 1'b1);
    for (int i = 0; i < 32; i++) begin
      step(1'b1, 1'b0);
      check_all();
    end
    chk("R4 dot wrapped", int'(rom_addr[4:0]), m_dot);

    // R2, R7, R8: walk columns through 11/12, 51/52, 63 and line wrap
    for (int i = 0; i < 1100; i++) begin
      step(1'b0, 1'b1);
      if (m_col == 11 || m_col == 12 || m_col == 51 || m_col == 52 ||
          m_col == 63 || m_col == 0 || (m_line == 0 && m_col < 3)) begin
        check_all();
      end
    end

    // R4: simultaneous strobes clear the dot index
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    chk("R4 both strobes", int'(rom_addr[4:0]), 0);
    check_all();

    // R1: reset mid-run returns to origin
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reapply ram_addr", int'(ram_addr), 0);
    chk("R1 reapply eoc_n", int'(eoc_n), 1);
    rst_n = 1'b1;
    m_col = 0; m_line = 0; m_dot = 0;
    @(negedge clk);
    @(negedge clk);
    check_all();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule